// File: doc/BRIEF.md
# Character LCD Host Bus Port

This block is the host-facing register port of a character LCD controller. A host processor reaches it over a parallel bus. The bus has a register-select line, a read/write line, an enable strobe and eight data lines. The block brings these asynchronous lines into the system clock domain. It decodes every completed access into one of four kinds: an instruction write, a data write, a status read or a data read. It then hands the controller core a one-cycle strobe for each write or data read.

On reads the block drives the data lines through a separate output-enable, which models the tri-state bus. A status read returns a busy flag and the core's address counter. Every accepted write sets the busy flag for a programmable number of clock cycles, which stands in for instruction execution. A write that arrives while the flag is set is dropped and reported. A 4-bit mode moves each byte as two halves on the upper data lines.

Top module: `lcd_host_port`

## Requirements
- R1: A completed write with busSel low and busRead low gives exactly one wrInstStrobe pulse, and wrByte then holds the bus byte.
- R2: A completed write with busSel high gives exactly one wrDataStrobe pulse, and wrByte then holds the bus byte.
- R3: A read with busSel low presents the busy flag on bit 7 and addrCount on bits 6..0. It raises no strobe.
- R4: A read with busSel high presents rdByte on the data lines. After the enable falls it gives exactly one rdDataStrobe pulse.
- R5: busDataOe is high only while the synchronised enable is high during a read. Whenever busDataOe is low, busDataOut is zero.
- R6: An accepted write sets the busy flag for busyLen clock cycles. It then clears by itself.
- R7: A write that completes while the busy flag is set raises wrDropped for one cycle and gives no write strobe.
- R8: In 4-bit mode (nibbleMode high) a byte is written in two enable cycles, the high half first and then the low half, both on lines 7..4. Lines 3..0 are ignored. The strobe comes only after the second cycle.
- R9: In 4-bit mode a read presents the high half of the byte on lines 7..4 in the first enable cycle and the low half in the second. Lines 3..0 read zero. rdDataStrobe comes only after the second cycle.
- R10: Each strobe lasts one clock cycle. Strobes and wrDropped never coincide.
- R11: After reset, busDataOe is low, all strobes are low and the busy flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| nibbleMode | input | 1 | 1 selects 4-bit bus operation |
| busyLen | input | 8 | Busy duration in clock cycles after an accepted write |
| busSel | input | 1 | Register select: 0 instruction/status, 1 data |
| busRead | input | 1 | 1 read cycle, 0 write cycle |
| busEn | input | 1 | Access strobe; data is taken on its falling edge |
| busDataIn | input | 8 | Data lines as driven by the host |
| busDataOut | output | 8 | Data lines as driven by the block |
| busDataOe | output | 1 | Output enable for busDataOut (tri-state control) |
| addrCount | input | 7 | Address counter from the controller core |
| rdByte | input | 8 | Read data from the controller core |
| wrByte | output | 8 | Assembled write byte for the core |
| wrInstStrobe | output | 1 | One-cycle instruction write pulse |
| wrDataStrobe | output | 1 | One-cycle data write pulse |
| rdDataStrobe | output | 1 | One-cycle data read pulse |
| wrDropped | output | 1 | One-cycle pulse for a write dropped while busy |

## Verification
A stuck or wrong half-byte phase shows up directly on the bus. In 4-bit mode it swaps halves or fires a strobe after a single enable cycle, within the next access. A busy counter that loads the wrong value or never clears shows up in the bit 7 of the next status read. It can also drop a legal write, which shows as a missing strobe a few cycles after the enable falls. Wrong decoding shows as the wrong strobe kind or a wrong wrByte three clock cycles after the falling enable edge reaches the block.

// File: rtl/lcd_host_pkg.sv
package lcd_host_pkg;
  // Control-to-datapath strobe bundle, valid for one cycle.
  typedef struct packed {
    logic latchHigh;   // store upper half of a 4-bit write
    logic wrInst;      // completed instruction write, accepted
    logic wrData;      // completed data write, accepted
    logic rdData;      // completed data read
    logic drop;        // completed write refused while busy
    logic drive;       // bus output enable
    logic lowHalf;     // current 4-bit transfer is the low half
  } hostStrb_t;
endpackage

// File: rtl/lcd_host_sync.sv
module lcd_host_sync #(
  parameter int W      = 11,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/lcd_host_ctrl.sv
module lcd_host_ctrl
  import lcd_host_pkg::*;
#(
  parameter int BUSY_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enS,
  input  logic              rsS,
  input  logic              rwS,
  input  logic              nibbleMode,
  input  logic [BUSY_W-1:0] busyLen,
  output hostStrb_t         strb,
  output logic              busy
);
  logic              enPrev;
  logic              phase;
  logic [BUSY_W-1:0] busyCnt;
  logic              fall;
  logic              complete;
  logic              isWrite;

  assign fall     = enPrev & ~enS;
  assign complete = fall & (~nibbleMode | phase);
  assign isWrite  = ~rwS;
  assign busy     = (busyCnt != '0);

  always_comb begin
    strb           = '0;
    strb.latchHigh = fall & nibbleMode & ~phase & isWrite;
    strb.wrInst    = complete & isWrite & ~rsS & ~busy;
    strb.wrData    = complete & isWrite &  rsS & ~busy;
    strb.rdData    = complete & rwS & rsS;
    strb.drop      = complete & isWrite & busy;
    strb.drive     = enS & rwS;
    strb.lowHalf   = nibbleMode & phase;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enPrev  <= 1'b0;
      phase   <= 1'b0;
      busyCnt <= '0;
    end else begin
      enPrev <= enS;
      if (!nibbleMode)  phase <= 1'b0;
      else if (fall)    phase <= ~phase;
      if (strb.wrInst || strb.wrData) busyCnt <= busyLen;
      else if (busy)                  busyCnt <= busyCnt - 1'b1;
    end
  end
endmodule

// File: rtl/lcd_host_dpath.sv
module lcd_host_dpath
  import lcd_host_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  hostStrb_t         strb,
  input  logic              nibbleMode,
  input  logic              busy,
  input  logic              rsS,
  input  logic [DATA_W-1:0] dataS,
  input  logic [DATA_W-2:0] addrCount,
  input  logic [DATA_W-1:0] rdByte,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  output logic [DATA_W-1:0] wrByte,
  output logic              wrInstStrobe,
  output logic              wrDataStrobe,
  output logic              rdDataStrobe,
  output logic              wrDropped
);
  localparam int HALF = DATA_W / 2;

  logic [HALF-1:0]   hiHalf;
  logic [DATA_W-1:0] inByte;
  logic [DATA_W-1:0] srcByte;
  logic [HALF-1:0]   srcHalf;

  assign inByte  = nibbleMode ? {hiHalf, dataS[DATA_W-1:HALF]} : dataS;
  assign srcByte = rsS ? rdByte : {busy, addrCount};
  assign srcHalf = strb.lowHalf ? srcByte[HALF-1:0] : srcByte[DATA_W-1:HALF];

  always_comb begin
    busDataOe  = strb.drive;
    busDataOut = '0;
    if (strb.drive)
      busDataOut = nibbleMode ? {srcHalf, {HALF{1'b0}}} : srcByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiHalf       <= '0;
      wrByte       <= '0;
      wrInstStrobe <= 1'b0;
      wrDataStrobe <= 1'b0;
      rdDataStrobe <= 1'b0;
      wrDropped    <= 1'b0;
    end else begin
      if (strb.latchHigh) hiHalf <= dataS[DATA_W-1:HALF];
      if (strb.wrInst || strb.wrData) wrByte <= inByte;
      wrInstStrobe <= strb.wrInst;
      wrDataStrobe <= strb.wrData;
      rdDataStrobe <= strb.rdData;
      wrDropped    <= strb.drop;
    end
  end
endmodule

// File: rtl/lcd_host_port.sv
module lcd_host_port
  import lcd_host_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BUSY_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              nibbleMode,
  input  logic [BUSY_W-1:0] busyLen,
  input  logic              busSel,
  input  logic              busRead,
  input  logic              busEn,
  input  logic [DATA_W-1:0] busDataIn,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  input  logic [DATA_W-2:0] addrCount,
  input  logic [DATA_W-1:0] rdByte,
  output logic [DATA_W-1:0] wrByte,
  output logic              wrInstStrobe,
  output logic              wrDataStrobe,
  output logic              rdDataStrobe,
  output logic              wrDropped
);
  localparam int SW = DATA_W + 3;

  logic [SW-1:0]     syncOut;
  logic              enS, rsS, rwS;
  logic [DATA_W-1:0] dataS;
  hostStrb_t         strb;
  logic              busy;

  lcd_host_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN),
    .din({busEn, busSel, busRead, busDataIn}),
    .dout(syncOut)
  );
  assign {enS, rsS, rwS, dataS} = syncOut;

  lcd_host_ctrl #(.BUSY_W(BUSY_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enS(enS), .rsS(rsS), .rwS(rwS),
    .nibbleMode(nibbleMode), .busyLen(busyLen), .strb(strb), .busy(busy)
  );

  lcd_host_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .nibbleMode(nibbleMode),
    .busy(busy), .rsS(rsS), .dataS(dataS), .addrCount(addrCount),
    .rdByte(rdByte), .busDataOut(busDataOut), .busDataOe(busDataOe),
    .wrByte(wrByte), .wrInstStrobe(wrInstStrobe),
    .wrDataStrobe(wrDataStrobe), .rdDataStrobe(rdDataStrobe),
    .wrDropped(wrDropped)
  );
endmodule

// File: rtl/lcd_host_port_chk.sv
module lcd_host_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              busDataOe,
  input logic [DATA_W-1:0] busDataOut,
  input logic              wrInstStrobe,
  input logic              wrDataStrobe,
  input logic              rdDataStrobe,
  input logic              wrDropped
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wrInstStrobe, wrDataStrobe, rdDataStrobe, wrDropped}));     // R10
  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !busDataOe |-> (busDataOut == '0));                                    // R5
  AST_WRITE_SETS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (wrInstStrobe || wrDataStrobe) |-> busy);                              // R6
  AST_DROP_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    wrDropped |-> $past(busy));                                            // R7
  AST_INST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    wrInstStrobe |=> !wrInstStrobe);                                       // R10
  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rdDataStrobe |=> !rdDataStrobe);                                       // R4
endmodule

bind lcd_host_port lcd_host_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .busDataOe(busDataOe),
  .busDataOut(busDataOut), .wrInstStrobe(wrInstStrobe),
  .wrDataStrobe(wrDataStrobe), .rdDataStrobe(rdDataStrobe),
  .wrDropped(wrDropped)
);

// File: tb/lcd_host_port_tb.sv
module lcd_host_port_tb;
  localparam int BUSY = 30;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       nibbleMode = 1'b0;
  logic [7:0] busyLen = 8'(BUSY);
  logic       busSel = 1'b0, busRead = 1'b0, busEn = 1'b0;
  logic [7:0] busDataIn = '0;
  logic [7:0] busDataOut;
  logic       busDataOe;
  logic [6:0] addrCount = 7'h5A;
  logic [7:0] rdByte = 8'hC3;
  logic [7:0] wrByte;
  logic       wrInstStrobe, wrDataStrobe, rdDataStrobe, wrDropped;

  int nTests = 0, nFail = 0;
  int nInst = 0, nData = 0, nRd = 0, nDrop = 0, nWide = 0;
  logic [7:0] lastByte = '0;
  logic prevInst = 0, prevData = 0, prevRd = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lcd_host_port u_dut (
    .clk(clk), .rstN(rstN), .nibbleMode(nibbleMode), .busyLen(busyLen),
    .busSel(busSel), .busRead(busRead), .busEn(busEn),
    .busDataIn(busDataIn), .busDataOut(busDataOut), .busDataOe(busDataOe),
    .addrCount(addrCount), .rdByte(rdByte), .wrByte(wrByte),
    .wrInstStrobe(wrInstStrobe), .wrDataStrobe(wrDataStrobe),
    .rdDataStrobe(rdDataStrobe), .wrDropped(wrDropped)
  );

  // Strobe monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (rstN) begin
      if (wrInstStrobe) begin nInst++; lastByte = wrByte; end
      if (wrDataStrobe) begin nData++; lastByte = wrByte; end
      if (rdDataStrobe) nRd++;
      if (wrDropped)    nDrop++;
      if ((wrInstStrobe && prevInst) || (wrDataStrobe && prevData) ||
          (rdDataStrobe && prevRd)) nWide++;
      prevInst = wrInstStrobe; prevData = wrDataStrobe; prevRd = rdDataStrobe;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic rs, input logic rw, input logic [7:0] d,
                        output logic [7:0] seen, output logic seenOe);
    @(negedge clk); busSel = rs; busRead = rw; busDataIn = d;
    repeat (2) @(negedge clk); busEn = 1'b1;
    repeat (5) @(negedge clk); seen = busDataOut; seenOe = busDataOe;
    busEn = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] s; logic o;
    check(busDataOe == 1'b0, "R11", busDataOe, 0);
    check(nInst + nData + nRd + nDrop == 0, "R11", nInst + nData + nRd + nDrop, 0);
    access(1'b0, 1'b1, 8'h00, s, o);
    check(s == {1'b0, addrCount}, "R11", s, {1'b0, addrCount});
    check(o == 1'b1, "R5", o, 1);
    check(nRd == 0, "R3", nRd, 0);
    check(busDataOe == 1'b0 && busDataOut == 8'h00, "R5", busDataOut, 0);
  endtask

  task automatic t_inst_write();
    logic [7:0] s; logic o; int i0 = nInst, d0 = nData;
    access(1'b0, 1'b0, 8'h38, s, o);
    check(o == 1'b0, "R5", o, 0);
    check(nInst == i0 + 1 && nData == d0, "R1", nInst - i0, 1);
    check(lastByte == 8'h38, "R1", lastByte, 8'h38);
    access(1'b0, 1'b1, 8'h00, s, o);
    check(s[7] == 1'b1, "R6", s[7], 1);
    check(s[6:0] == addrCount, "R3", s[6:0], addrCount);
    repeat (BUSY + 10) @(negedge clk);
    access(1'b0, 1'b1, 8'h00, s, o);
    check(s[7] == 1'b0, "R6", s[7], 0);
  endtask

  task automatic t_data_write();
    logic [7:0] s; logic o; int i0 = nInst, d0 = nData;
    access(1'b1, 1'b0, 8'h41, s, o);
    check(nData == d0 + 1 && nInst == i0, "R2", nData - d0, 1);
    check(lastByte == 8'h41, "R2", lastByte, 8'h41);
    repeat (BUSY + 10) @(negedge clk);
  endtask

  task automatic t_data_read();
    logic [7:0] s; logic o; int r0 = nRd;
    access(1'b1, 1'b1, 8'h00, s, o);
    check(s == 8'hC3 && o == 1'b1, "R4", s, 8'hC3);
    check(nRd == r0 + 1, "R4", nRd - r0, 1);
    check(busDataOe == 1'b0, "R5", busDataOe, 0);
  endtask

  task automatic t_busy_drop();
    logic [7:0] s; logic o; int i0 = nInst, d0 = nData, p0 = nDrop;
    access(1'b0, 1'b0, 8'h01, s, o);
    access(1'b1, 1'b0, 8'h55, s, o);
    check(nDrop == p0 + 1, "R7", nDrop - p0, 1);
    check(nData == d0 && nInst == i0 + 1, "R7", nData - d0, 0);
    check(lastByte == 8'h01, "R7", lastByte, 8'h01);
    repeat (BUSY + 10) @(negedge clk);
  endtask

  task automatic t_nibble_write();
    logic [7:0] s; logic o; int d0 = nData;
    nibbleMode = 1'b1;
    access(1'b1, 1'b0, 8'hA7, s, o);
    check(nData == d0, "R8", nData - d0, 0);
    access(1'b1, 1'b0, 8'h5C, s, o);
    check(nData == d0 + 1, "R8", nData - d0, 1);
    check(lastByte == 8'hA5, "R8", lastByte, 8'hA5);
    repeat (BUSY + 10) @(negedge clk);
  endtask

  task automatic t_nibble_read();
    logic [7:0] s1, s2; logic o; int r0 = nRd;
    access(1'b1, 1'b1, 8'h0F, s1, o);
    check(s1 == 8'hC0, "R9", s1, 8'hC0);
    check(nRd == r0, "R9", nRd - r0, 0);
    access(1'b1, 1'b1, 8'h0F, s2, o);
    check(s2 == 8'h30, "R9", s2, 8'h30);
    check(nRd == r0 + 1, "R9", nRd - r0, 1);
    nibbleMode = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_inst_write();
    t_data_write();
    t_data_read();
    t_busy_drop();
    t_nibble_write();
    t_nibble_read();
    check(nWide == 0, "R10", nWide, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule